// File: doc/BRIEF.md
# Header Match and Mask Router

Each cell that arrives on the receive path carries a 32-bit routing header. This block compares that header against a set of per-port rules and decides which receive FIFO ports get a copy of the cell. There is one rule per port. Each rule is a value word and a mask word. A mask bit of 1 means the header bit at that position is ignored. A mask bit of 0 means the header bit must equal the value bit. Because of the mask, one rule can accept a whole range of headers.

The rules are tested independently, so one cell can match several rules. Such a cell is copied to every matching port; no single winner is chosen. The result is a registered destination vector with a valid flag. It appears one clock after the header strobe. If no rule matches, the cell is dropped and a one-clock discard pulse is raised. Each port also has a saturating 16-bit count of the cells routed to it, and a synchronous clear input resets all of these counts.

Top module: `hdr_route_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `dst_vec`, `dst_vld`, `drop_pulse` and every count in `hit_cnt` are zero.
- R2: A header bit at a position where the rule's mask bit is 0 must equal the value bit, otherwise that port's bit in `dst_vec` is 0.
- R3: A header bit at a position where the mask bit is 1 has no effect on the match, so one rule accepts every header in the masked range.
- R4: Every port whose rule matches has its bit set in `dst_vec`, so a cell can go to several ports at once. Bit p of `dst_vec` belongs to port p, and rule p sits at bits [p*32 +: 32] of `rule_val` and `rule_msk`.
- R5: A header presented with `hdr_vld` high at clock edge k shows up as `dst_vld` = 1 and its `dst_vec` in the cycle after edge k. In a cycle with no header, `dst_vld` and `dst_vec` are 0.
- R6: The rule words sampled on the same edge as `hdr_vld` decide that cell. A rule change on the following edge does not affect it.
- R7: A valid cell that matches no rule produces `dst_vec` = 0 and `drop_pulse` high for exactly that one cycle. `drop_pulse` is low at all other times.
- R8: Count p (`hit_cnt[p*16 +: 16]`) goes up by one on the same edge that registers a cell whose `dst_vec` bit p is set.
- R9: A count that has reached 65535 stays at 65535 as further matching cells arrive.
- R10: `cnt_clr` high at an edge sets every count to zero on that edge. It takes precedence over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_vld | input | 1 | Header strobe, one cell per high cycle |
| hdr_word | input | 32 | Routing header; bytes 1–2 in [31:16], bytes 3–4 in [15:0] |
| rule_val | input | 128 | Per-port match values, port p at [p*32 +: 32] |
| rule_msk | input | 128 | Per-port masks, 1 = ignore bit, port p at [p*32 +: 32] |
| cnt_clr | input | 1 | Synchronous clear of all hit counts |
| dst_vec | output | 4 | Registered destination vector, bit p = port p |
| dst_vld | output | 1 | Destination vector is valid this cycle |
| drop_pulse | output | 1 | One-cycle pulse for a cell that no rule accepts |
| hit_cnt | output | 64 | Saturating per-port counts, port p at [p*16 +: 16] |

## Verification
The bench targets headers that differ from a rule by one bit inside the exact region, and headers that differ only in the ignored region. A design that inverts the mask sense, or uses it the wrong way, turns these into false drops or false hits. Cells that match three rules at once expose a design that forwards only one winner. Back-to-back cells whose rules change on the very next edge expose a design that reads the rules one cycle late. Long runs of matches drive one count past 65535, which catches a counter that wraps to zero. A clear issued on the same edge as a matching cell catches a counter that gives the increment priority over the clear.

// File: rtl/hdr_route_pkg.sv
package hdr_route_pkg;
  localparam int DEF_NPORT = 4;
  localparam int DEF_HDR_W = 32;
  localparam int DEF_CNT_W = 16;
endpackage

// File: rtl/hdr_rule_cmp.sv
// One masked rule: hit when every cared-for header bit equals the value bit.
module hdr_rule_cmp #(
  parameter int HDR_W = 32
) (
  input  logic [HDR_W-1:0] hdr,
  input  logic [HDR_W-1:0] val,
  input  logic [HDR_W-1:0] msk,
  output logic             hit
);
  logic [HDR_W-1:0] diff;

  always_comb begin
    diff = (hdr ^ val) & ~msk;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/hdr_hit_counter.sv
// Saturating event counter with synchronous clear that beats increment.
module hdr_hit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && cnt != TOP) begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/hdr_route_top.sv
module hdr_route_top
  import hdr_route_pkg::*;
#(
  parameter int NPORT = DEF_NPORT,
  parameter int HDR_W = DEF_HDR_W,
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hdr_vld,
  input  logic [HDR_W-1:0]       hdr_word,
  input  logic [NPORT*HDR_W-1:0] rule_val,
  input  logic [NPORT*HDR_W-1:0] rule_msk,
  input  logic                   cnt_clr,
  output logic [NPORT-1:0]       dst_vec,
  output logic                   dst_vld,
  output logic                   drop_pulse,
  output logic [NPORT*CNT_W-1:0] hit_cnt
);
  logic [NPORT-1:0] rule_hit;
  logic [NPORT-1:0] take;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    hdr_rule_cmp #(.HDR_W(HDR_W)) u_cmp (
      .hdr (hdr_word),
      .val (rule_val[p*HDR_W +: HDR_W]),
      .msk (rule_msk[p*HDR_W +: HDR_W]),
      .hit (rule_hit[p])
    );

    assign take[p] = hdr_vld & rule_hit[p];

    hdr_hit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (cnt_clr),
      .inc (take[p]),
      .cnt (hit_cnt[p*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_vec    <= '0;
      dst_vld    <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      dst_vec    <= take;
      dst_vld    <= hdr_vld;
      drop_pulse <= hdr_vld && (rule_hit == '0);
    end
  end
endmodule

// File: rtl/hdr_route_chk.sv
module hdr_route_chk #(
  parameter int NPORT = 4,
  parameter int HDR_W = 32,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   hdr_vld,
  input logic [HDR_W-1:0]       hdr_word,
  input logic [NPORT*HDR_W-1:0] rule_val,
  input logic [NPORT*HDR_W-1:0] rule_msk,
  input logic                   cnt_clr,
  input logic [NPORT-1:0]       dst_vec,
  input logic                   dst_vld,
  input logic                   drop_pulse,
  input logic [NPORT*CNT_W-1:0] hit_cnt
);
  // R5
  vld_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dst_vld == $past(hdr_vld));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dst_vld |-> dst_vec == '0);

  // R7
  drop_only_empty_chk: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> (dst_vld && dst_vec == '0));

  // R7
  empty_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (dst_vld && dst_vec == '0) |-> drop_pulse);

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R2 R3 R6
    port_match_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hdr_vld)) |->
        dst_vec[p] == ((($past(hdr_word) ^ $past(rule_val[p*HDR_W +: HDR_W]))
                        & ~$past(rule_msk[p*HDR_W +: HDR_W])) == '0));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(cnt_clr)) |-> hit_cnt[p*CNT_W +: CNT_W] == '0);

    // R8 R9
    step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cnt_clr)) |->
        ({1'b0, hit_cnt[p*CNT_W +: CNT_W]} == {1'b0, $past(hit_cnt[p*CNT_W +: CNT_W])} ||
         {1'b0, hit_cnt[p*CNT_W +: CNT_W]} == {1'b0, $past(hit_cnt[p*CNT_W +: CNT_W])} + 1'b1));

    // R8
    count_moves_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cnt_clr) &&
       hit_cnt[p*CNT_W +: CNT_W] != $past(hit_cnt[p*CNT_W +: CNT_W])) |-> dst_vec[p]);
  end
endmodule

bind hdr_route_top hdr_route_chk #(.NPORT(NPORT), .HDR_W(HDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .hdr_vld(hdr_vld), .hdr_word(hdr_word),
  .rule_val(rule_val), .rule_msk(rule_msk), .cnt_clr(cnt_clr),
  .dst_vec(dst_vec), .dst_vld(dst_vld), .drop_pulse(drop_pulse), .hit_cnt(hit_cnt)
);

// File: tb/sim_hdr_route_top.sv
`timescale 1ns/1ps
module sim_hdr_route_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         hdr_vld = 1'b0;
  logic [31:0]  hdr_word = '0;
  logic [31:0]  rv [4];
  logic [31:0]  rm [4];
  logic [127:0] rule_val, rule_msk;
  logic         cnt_clr = 1'b0;
  logic [3:0]   dst_vec;
  logic         dst_vld, drop_pulse;
  logic [63:0]  hit_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int p = 0; p < 4; p++) begin
      rule_val[p*32 +: 32] = rv[p];
      rule_msk[p*32 +: 32] = rm[p];
    end
  end

  hdr_route_top u0 (
    .clk(clk), .rst(rst), .hdr_vld(hdr_vld), .hdr_word(hdr_word),
    .rule_val(rule_val), .rule_msk(rule_msk), .cnt_clr(cnt_clr),
    .dst_vec(dst_vec), .dst_vld(dst_vld), .drop_pulse(drop_pulse), .hit_cnt(hit_cnt)
  );

  // behavioural reference
  logic [3:0] e_vec = '0;
  bit         e_vld = 0;
  bit         e_drop = 0;
  int         e_cnt [4] = '{0, 0, 0, 0};

  function automatic bit rule_ok(logic [31:0] h, logic [31:0] v, logic [31:0] m);
    for (int b = 0; b < 32; b++)
      if (!m[b] && (h[b] !== v[b])) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_vec = '0; e_vld = 0; e_drop = 0;
      for (int p = 0; p < 4; p++) e_cnt[p] = 0;
    end else begin
      logic [3:0] m;
      for (int p = 0; p < 4; p++) m[p] = hdr_vld && rule_ok(hdr_word, rv[p], rm[p]);
      e_vec  = m;
      e_vld  = hdr_vld;
      e_drop = hdr_vld && (m == 4'd0);
      for (int p = 0; p < 4; p++) begin
        if (cnt_clr) e_cnt[p] = 0;
        else if (m[p] && e_cnt[p] < 65535) e_cnt[p] = e_cnt[p] + 1;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2/R3/R4 dst_vec vs model", dst_vec, e_vec);
      chk("R5 dst_vld vs model", dst_vld, e_vld);
      chk("R7 drop_pulse vs model", drop_pulse, e_drop);
      for (int p = 0; p < 4; p++)
        chk("R8/R9/R10 hit_cnt vs model", hit_cnt[p*16 +: 16], e_cnt[p]);
    end
  end

  task automatic cyc(bit v, logic [31:0] h, bit c);
    @(negedge clk);
    hdr_vld = v; hdr_word = h; cnt_clr = c;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL R5 watchdog act=%0d exp=%0d", cycles, 190000);
      finish_run();
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) begin rv[p] = '0; rm[p] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset dst_vec", dst_vec, 0);
    chk("R1 reset dst_vld", dst_vld, 0);
    chk("R1 reset drop", drop_pulse, 0);
    chk("R1 reset counts", hit_cnt, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", {dst_vec, dst_vld, drop_pulse}, 0);

    rv[0] = 32'h00A5_0010; rm[0] = 32'h0000_0000;
    rv[1] = 32'h00A5_0000; rm[1] = 32'h0000_FFFF;
    rv[2] = 32'h0000_0000; rm[2] = 32'hFFFF_FFFF;
    rv[3] = 32'h1234_5678; rm[3] = 32'h0000_000F;

    cyc(1, 32'h00A5_0010, 0); cyc(0, 0, 0);
    chk("R4 multicast to ports 0,1,2", dst_vec, 4'b0111);
    chk("R5 valid after header", dst_vld, 1);
    cyc(1, 32'h00A5_0011, 0); cyc(0, 0, 0);
    chk("R2 exact bit mismatch removes port 0", dst_vec, 4'b0110);
    cyc(1, 32'h1234_567C, 0); cyc(0, 0, 0);
    chk("R3 masked low bits ignored on port 3", dst_vec, 4'b1100);
    cyc(1, 32'h00A5_BEEF, 0); cyc(0, 0, 0);
    chk("R3 range rule port 1", dst_vec[1], 1);
    @(negedge clk);
    chk("R5 idle cycle vec zero", {dst_vld, dst_vec}, 0);

    rv[2] = 32'hFFFF_FFFF; rm[2] = 32'h0000_0000;
    cyc(1, 32'h0BAD_0000, 0); cyc(0, 0, 0);
    chk("R7 no match drops", {dst_vld, dst_vec, drop_pulse}, 6'b1_0000_1);
    @(negedge clk);
    chk("R7 drop lasts one cycle", drop_pulse, 0);

    // R6: rules change on the edge after the cell
    cyc(1, 32'h1234_5670, 0);
    @(negedge clk);
    chk("R6 cell uses rules of its own edge", dst_vec[3], 1);
    rv[3] = 32'h0;
    @(negedge clk);
    chk("R6 next cell sees new rule", dst_vec[3], 0);
    hdr_vld = 0;
    rv[3] = 32'h1234_5678;
    @(negedge clk);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0)
        for (int p = 0; p < 4; p++) begin
          rv[p] = $urandom;
          rm[p] = $urandom & $urandom & $urandom;
        end
      begin
        logic [31:0] h;
        h = rv[$urandom % 4] ^ ($urandom & $urandom & $urandom & $urandom);
        if ($urandom % 5 == 0) h = $urandom;
        cyc(($urandom % 4) != 0, h, ($urandom % 97) == 0);
      end
    end

    // saturation on port 0, others never match
    rv[0] = '0; rm[0] = '1;
    for (int p = 1; p < 4; p++) begin rv[p] = '1; rm[p] = '0; end
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    chk("R10 clear zeroes counts", hit_cnt, 0);
    for (int i = 0; i < 65540; i++) cyc(1, 32'h0, 0);
    cyc(0, 0, 0);
    chk("R9 port 0 saturates", hit_cnt[15:0], 16'hFFFF);
    chk("R8 non-matching ports stay zero", hit_cnt[63:16], 0);
    cyc(1, 32'h0, 1);
    cyc(0, 0, 0);
    chk("R10 clear beats increment", hit_cnt[15:0], 0);
    cyc(1, 32'h0, 0);
    cyc(0, 0, 0);
    chk("R8 count resumes after clear", hit_cnt[15:0], 1);

    @(negedge clk);
    finish_run();
  end
endmodule